// File: doc/BRIEF.md
# Register Dependence Hazard Detector

This block decides whether a new instruction may enter a pipeline while older instructions are still in progress. Each instruction is described by two 16-bit register masks. The read mask has one bit set for each register the instruction reads. The write mask has one bit set for each register it writes. The detector keeps up to four older instructions in a small table of slots. It compares the candidate against every occupied slot in the same cycle.

A conflict is the bitwise AND of two masks, reduced with OR. Three kinds of conflict are reported on separate flags. A read-after-write conflict is an older write mask meeting the candidate's read mask. A write-after-write conflict is an older write mask meeting the candidate's write mask. A write-after-read conflict is an older read mask meeting the candidate's write mask. The block also stalls when every slot is occupied.

When no conflict is found, the candidate is accepted. Its masks are written into the lowest free slot, and the slot number is reported. When an older instruction finishes, its own strobe bit frees its slot in that same cycle. The finished slot is left out of the comparison, and its slot can be reused in that cycle.

Top module: `hzd_chk`

## Requirements
- R1: After synchronous reset, no slot is occupied: a valid candidate with any masks sees stall=0, full=0 and all three hazard flags low.
- R2: haz_raw and stall are 1 when an occupied slot's write mask shares a bit with the candidate's read mask.
- R3: haz_waw and stall are 1 when an occupied slot's write mask shares a bit with the candidate's write mask.
- R4: haz_war and stall are 1 when an occupied slot's read mask shares a bit with the candidate's write mask.
- R5: The three flags are independent. A read mask shared with an older read mask raises no flag. One candidate may raise several flags at once, from the same slot or from different slots.
- R6: The candidate is compared against all occupied slots in parallel. A conflict with any single slot stalls it.
- R7: Bit i of done frees slot i in the cycle it is high. If no other slot conflicts, stall drops in that same cycle. If another occupied slot still conflicts, stall stays high.
- R8: When all four slots stay occupied through the cycle, full=1 and stall=1, and iss=0. If done frees a slot in that cycle, full=0.
- R9: When cand_vld=1 and stall=0, iss=1 and iss_slot gives the lowest slot index that is free in that cycle. Slots are numbered 0 to 3, and a slot freed by done in that cycle counts as free. From the next cycle on, the slot holds the candidate's masks.
- R10: When cand_vld=0, stall, iss, full and all hazard flags are 0, and nothing is stored in any slot.
- R11: A done bit for a slot that is not occupied has no effect on any slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_vld | input | 1 | A candidate instruction is presented |
| cand_dom | input | 16 | Registers the candidate reads, one bit per register |
| cand_rng | input | 16 | Registers the candidate writes, one bit per register |
| done | input | 4 | Completion strobe, one bit per slot |
| stall | output | 1 | Candidate must be held this cycle |
| haz_raw | output | 1 | Read-after-write conflict found |
| haz_waw | output | 1 | Write-after-write conflict found |
| haz_war | output | 1 | Write-after-read conflict found |
| full | output | 1 | No slot is free this cycle |
| iss | output | 1 | Candidate accepted this cycle |
| iss_slot | output | 2 | Slot that receives the accepted candidate |

## Verification
The bench targets several corner cases, and each one shows what a faulty design would do.
- Two instructions that only read the same registers must not stall; a design that compared read masks with each other would block them.
- A strobe that frees the only conflicting slot must release the candidate in that same cycle, and the candidate must be placed in the slot just freed. A design that used the slot state from before the strobe would stall one cycle too long or pick a higher slot.
- A strobe for one conflicting slot must leave the stall high while a second slot still conflicts.
- A strobe aimed at an empty slot must not disturb any stored entry.
- A full table must block an otherwise clean candidate until a slot frees.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int NREG = 16;
  typedef logic [NREG-1:0] rmask_t;
  typedef struct packed {
    rmask_t dom;
    rmask_t rng;
  } ops_t;
  typedef struct packed {
    logic raw;
    logic waw;
    logic war;
  } haz_t;
endpackage

// File: rtl/hzd_slots.sv
module hzd_slots
  import hzd_pkg::*;
#(
  parameter int NSLOT = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSLOT-1:0]       done,
  input  logic [NSLOT-1:0]       alloc,
  input  ops_t                   wr_ops,
  output logic [NSLOT-1:0]       live,
  output ops_t [NSLOT-1:0]       ent
);
  logic [NSLOT-1:0] occ;

  // a slot retiring this cycle no longer takes part in comparison
  assign live = occ & ~done;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= live | alloc;
  end

  // payload needs no reset: occupancy qualifies it
  for (genvar i = 0; i < NSLOT; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (alloc[i]) ent[i] <= wr_ops;
    end
  end
endmodule

// File: rtl/hzd_cmp.sv
module hzd_cmp
  import hzd_pkg::*;
(
  input  logic en,
  input  ops_t old_ops,
  input  ops_t new_ops,
  output haz_t hit
);
  always_comb begin
    hit.raw = en & |(old_ops.rng & new_ops.dom);
    hit.waw = en & |(old_ops.rng & new_ops.rng);
    hit.war = en & |(old_ops.dom & new_ops.rng);
  end
endmodule

// File: rtl/hzd_alloc.sv
module hzd_alloc #(
  parameter int NSLOT = 4,
  localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [NSLOT-1:0] busy,
  output logic [NSLOT-1:0] pick_oh,
  output logic [IW-1:0]    pick_idx,
  output logic             any_free
);
  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    any_free = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        pick_oh  = '0;
        pick_oh[i] = 1'b1;
        pick_idx = IW'(i);
        any_free = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hzd_chk.sv
module hzd_chk
  import hzd_pkg::*;
#(
  parameter int NSLOT = 4,
  localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cand_vld,
  input  logic [NREG-1:0]  cand_dom,
  input  logic [NREG-1:0]  cand_rng,
  input  logic [NSLOT-1:0] done,
  output logic             stall,
  output logic             haz_raw,
  output logic             haz_waw,
  output logic             haz_war,
  output logic             full,
  output logic             iss,
  output logic [IW-1:0]    iss_slot
);
  ops_t               cand;
  ops_t [NSLOT-1:0]   ent;
  haz_t [NSLOT-1:0]   hit;
  logic [NSLOT-1:0]   live, pick_oh, alloc;
  logic               any_free;
  logic               raw_any, waw_any, war_any;

  assign cand.dom = cand_dom;
  assign cand.rng = cand_rng;

  hzd_slots #(.NSLOT(NSLOT)) u_slots (
    .clk(clk), .rst(rst), .done(done), .alloc(alloc),
    .wr_ops(cand), .live(live), .ent(ent)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
    hzd_cmp u_cmp (.en(live[i]), .old_ops(ent[i]), .new_ops(cand), .hit(hit[i]));
  end

  hzd_alloc #(.NSLOT(NSLOT)) u_alloc (
    .busy(live), .pick_oh(pick_oh), .pick_idx(iss_slot), .any_free(any_free)
  );

  always_comb begin
    raw_any = 1'b0;
    waw_any = 1'b0;
    war_any = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      raw_any |= hit[i].raw;
      waw_any |= hit[i].waw;
      war_any |= hit[i].war;
    end
  end

  assign haz_raw = cand_vld & raw_any;
  assign haz_waw = cand_vld & waw_any;
  assign haz_war = cand_vld & war_any;
  assign full    = cand_vld & ~any_free;
  assign stall   = haz_raw | haz_waw | haz_war | full;
  assign iss     = cand_vld & ~stall;
  assign alloc   = iss ? pick_oh : '0;
endmodule

// File: rtl/hzd_sva.sv
module hzd_sva #(
  parameter int NSLOT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cand_vld,
  input logic [15:0]      cand_dom,
  input logic [15:0]      cand_rng,
  input logic [NSLOT-1:0] done,
  input logic             stall,
  input logic             haz_raw,
  input logic             haz_waw,
  input logic             haz_war,
  input logic             full,
  input logic             iss
);
  // R1
  empty_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !full);

  // R2
  raw_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    haz_raw |-> (|cand_dom) && stall);

  // R4
  wr_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    (haz_waw || haz_war) |-> (|cand_rng) && stall);

  // R9
  issued_is_tracked_chk: assert property (@(posedge clk) disable iff (rst)
    (iss && (|cand_rng) && done == '0) |=>
      (!(cand_vld && $stable(cand_rng) && done == '0) || haz_waw));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cand_vld |-> !stall && !iss);
endmodule

bind hzd_chk hzd_sva #(.NSLOT(NSLOT)) u_sva (
  .clk(clk), .rst(rst), .cand_vld(cand_vld), .cand_dom(cand_dom),
  .cand_rng(cand_rng), .done(done), .stall(stall), .haz_raw(haz_raw),
  .haz_waw(haz_waw), .haz_war(haz_war), .full(full), .iss(iss)
);

// File: tb/sim_hzd_chk.sv
`timescale 1ns/1ps
module sim_hzd_chk;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cand_vld = 1'b0;
  logic [15:0] cand_dom = '0;
  logic [15:0] cand_rng = '0;
  logic [3:0]  done = '0;
  logic        stall, haz_raw, haz_waw, haz_war, full, iss;
  logic [1:0]  iss_slot;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hzd_chk u0 (
    .clk(clk), .rst(rst), .cand_vld(cand_vld), .cand_dom(cand_dom),
    .cand_rng(cand_rng), .done(done), .stall(stall), .haz_raw(haz_raw),
    .haz_waw(haz_waw), .haz_war(haz_war), .full(full), .iss(iss),
    .iss_slot(iss_slot)
  );

  task automatic drv(input bit v, input logic [15:0] d, input logic [15:0] r,
                     input logic [3:0] dn);
    @(negedge clk);
    cand_vld = v; cand_dom = d; cand_rng = r; done = dn;
    #1;
  endtask

  task automatic expect_out(input string req, input bit st, input bit ra,
                            input bit ww, input bit wr, input bit fu,
                            input bit is, input logic [1:0] sl);
    logic [7:0] act, exp;
    act = {st, ra, ww, wr, fu, is, (is ? iss_slot : 2'b00)};
    exp = {st, ra, ww, wr, fu, is, (is ? sl : 2'b00)};
    act = {stall, haz_raw, haz_waw, haz_war, full, iss, (iss ? iss_slot : 2'b00)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s stall/raw/waw/war/full/iss/slot act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic t_reset();
    drv(0, 16'h0001, 16'h0001, 4'h0);
    expect_out("R10", 0, 0, 0, 0, 0, 0, 2'd0);
    drv(1, 16'hFFFF, 16'hFFFF, 4'h0);
    expect_out("R1", 0, 0, 0, 0, 0, 1, 2'd0);
    drv(0, 16'h0, 16'h0, 4'hF);   // free slot 0 again
  endtask

  task automatic t_classes();
    drv(1, 16'h0006, 16'h0001, 4'h0);   // slot0: reads r1,r2 writes r0
    expect_out("R9", 0, 0, 0, 0, 0, 1, 2'd0);
    drv(1, 16'h0001, 16'h0100, 4'h0);
    expect_out("R2", 1, 1, 0, 0, 0, 0, 2'd0);
    drv(1, 16'h0000, 16'h0001, 4'h0);
    expect_out("R3", 1, 0, 1, 0, 0, 0, 2'd0);
    drv(1, 16'h0000, 16'h0004, 4'h0);
    expect_out("R4", 1, 0, 0, 1, 0, 0, 2'd0);
    drv(1, 16'h0006, 16'h0800, 4'h0);   // shared reads only -> slot1
    expect_out("R5", 0, 0, 0, 0, 0, 1, 2'd1);
    drv(1, 16'h0800, 16'h0002, 4'h0);   // raw vs slot1, war vs slot0
    expect_out("R6", 1, 1, 0, 1, 0, 0, 2'd0);
    drv(1, 16'h0001, 16'h0001, 4'h0);   // raw+waw from slot0 alone
    expect_out("R5", 1, 1, 1, 0, 0, 0, 2'd0);
  endtask

  task automatic t_release();
    drv(1, 16'h0001, 16'h0000, 4'h1);   // slot0 retires, reuse it
    expect_out("R7", 0, 0, 0, 0, 0, 1, 2'd0);
    drv(1, 16'h0800, 16'h0000, 4'h4);   // strobe to empty slot2
    expect_out("R11", 1, 1, 0, 0, 0, 0, 2'd0);
    drv(1, 16'h0000, 16'h0800, 4'h0);   // slot1 still holds r11 write
    expect_out("R11", 1, 0, 1, 0, 0, 0, 2'd0);
    drv(1, 16'h0000, 16'h0001, 4'h0);   // slot0 now reads r0
    expect_out("R4", 1, 0, 0, 1, 0, 0, 2'd0);
  endtask

  task automatic t_full();
    drv(1, 16'h0000, 16'h1000, 4'h0);
    expect_out("R9", 0, 0, 0, 0, 0, 1, 2'd2);
    drv(1, 16'h0000, 16'h2000, 4'h0);
    expect_out("R9", 0, 0, 0, 0, 0, 1, 2'd3);
    drv(1, 16'h0000, 16'h4000, 4'h0);
    expect_out("R8", 1, 0, 0, 0, 1, 0, 2'd0);
    drv(1, 16'h0000, 16'h4000, 4'h2);   // slot1 retires
    expect_out("R8", 0, 0, 0, 0, 0, 1, 2'd1);
  endtask

  task automatic t_multi_hold();
    drv(0, 16'h3000, 16'h0000, 4'h0);
    expect_out("R10", 0, 0, 0, 0, 0, 0, 2'd0);
    drv(1, 16'h3000, 16'h0000, 4'h4);   // slot2 retires, slot3 still conflicts
    expect_out("R7", 1, 1, 0, 0, 0, 0, 2'd0);
    drv(1, 16'h3000, 16'h0000, 4'h8);   // slot3 retires -> accepted in slot2
    expect_out("R7", 0, 0, 0, 0, 0, 1, 2'd2);
    drv(1, 16'h0000, 16'h0000, 4'h0);   // slots 0,1,2 busy, 3 free
    expect_out("R9", 0, 0, 0, 0, 0, 1, 2'd3);
    drv(0, 16'h0, 16'h0, 4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_classes();
    t_release();
    t_full();
    t_multi_hold();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule